// File: doc/BRIEF.md
# Serial Flash Program-Cycle Status Tracker

This block keeps the write-status state of a serial NOR flash slave. An SPI front end, which is not part of this block, decodes the commands. It passes in a page-program request with its target page, write-enable and protect-write requests, and the live chip-select line. The block holds the write-enable latch and the three protect bits. It checks each program request against the protected upper part of the array. When a request is accepted, it runs a self-timed busy window of a fixed number of clock cycles.

The busy window opens only when chip select returns high to close the frame that carried the program command. It does not open when the command's last bit arrives. While the window runs, the status byte stays readable, so a status-read command can poll the busy flag. When the window closes, the busy flag and the write-enable latch drop together. A request that is refused because the latch is clear, or because the page is protected, starts nothing. After a protection refusal the latch stays set, so software can see from the status byte that the command was refused. A separate erase engine can share the busy flag through a hook input.

Top module: `pgm_status_tracker`

## Requirements
- R1: After reset the status byte reads 0: not busy, latch clear, protect bits 0.
- R2: A write-enable request sets the latch (status bit 1) on the next clock edge, but only while the busy flag (status bit 0) is 0. A write-enable request made while busy is ignored.
- R3: A page-program request captured while chip select (`cs_n`, active low) is low starts nothing while `cs_n` stays low. The cycle starts on the first clock edge at which `cs_n` is sampled high after being low in that frame.
- R4: Once a cycle starts, status bit 0 reads 1 for exactly PROG_CYCLES clock cycles and then returns to 0.
- R5: On the clock edge that ends the cycle, the latch clears together with the busy flag.
- R6: A page-program frame that closes while the latch is clear is ignored: no busy period starts.
- R7: Protect value n is held in status bits 4:2. For n from 1 to 7, the protected pages are those whose six top page-address bits are at least 64 - 2^(n-1). For n = 0 no page is protected. A request to a protected page is dropped: the busy flag stays 0 and the latch stays 1.
- R8: A page-program frame that closes while a cycle runs is ignored. The running cycle is not extended.
- R9: A protect-write request loads `bp_wr_val` into status bits 4:2 and clears the latch on the next edge. This happens only when the latch is 1 and the busy flag is 0; otherwise the request is ignored. If a protect-write and a write-enable request arrive in the same cycle, the protect-write takes precedence.
- R10: While `erase_busy` is 1, status bit 0 reads 1, and a page-program frame that closes in that time is dropped.
- R11: Status bits 7:5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select from the front end, active low |
| pp_req | input | 1 | Page-program command decoded in the current frame (one-cycle pulse) |
| pp_page | input | PAGE_AW | Target page of the program command |
| wren_req | input | 1 | Write-enable command pulse |
| bp_wr_req | input | 1 | Protect-bit write command pulse |
| bp_wr_val | input | 3 | New protect value |
| erase_busy | input | 1 | Busy hook from a shared erase engine |
| status | output | 8 | Status byte: bit 0 busy, bit 1 latch, bits 4:2 protect, bits 7:5 zero |

## Verification
The latch and the protect bits change one edge after the request that changes them. The busy flag rises on the edge that samples `cs_n` high, and it falls PROG_CYCLES edges after that. The `erase_busy` hook reaches status bit 0 without any register in between. The bench drives inputs on the falling edge and reads the status byte on the next falling edge. It counts the busy window one step at a time, so each check lands in the exact cycle the requirement names. A cycle model in the bench updates on every rising edge from the same inputs, and the status byte is compared with it on every falling edge.

// File: rtl/pgm_status_pkg.sv
// Shared constants, status layout and protection decode for the tracker.
package pgm_status_pkg;

    localparam int BP_W     = 3;
    localparam int STAT_W   = 8;
    localparam int PROT_TOP = 6;   // page-address bits used for the protect decode

    typedef struct packed {
        logic [2:0]      rsvd;
        logic [BP_W-1:0] bp;
        logic            wel;
        logic            wip;
    } stat_t;

    // True when the top page bits fall in the protected upper region for bp.
    function automatic logic prot_hit(input logic [PROT_TOP-1:0] top,
                                      input logic [BP_W-1:0]     bp);
        logic [PROT_TOP:0] floor_v;
        if (bp == '0) begin
            return 1'b0;
        end
        floor_v = 7'd64 - (7'd1 << (bp - 3'd1));
        return ({1'b0, top} >= floor_v);
    endfunction

endpackage

// File: rtl/pst_frame_capture.sv
// Frame capture: detects the rising edge of chip select and holds a
// page-program request, with its page, until that frame closes.
// Assumes cs_n is already synchronous to clk.
module pst_frame_capture #(
    parameter int PAGE_AW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               pp_req,
    input  logic [PAGE_AW-1:0] pp_page,
    output logic               cs_rise,
    output logic               pend,
    output logic [PAGE_AW-1:0] pend_page
);

    logic cs_q;

    // Previous chip-select level, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    assign cs_rise = cs_n & ~cs_q;

    // Pending request: cleared when the frame closes, set by a request inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_page <= '0;
        end else if (cs_rise) begin
            pend      <= 1'b0;
        end else if (!cs_n && pp_req) begin
            pend      <= 1'b1;
            pend_page <= pp_page;
        end
    end

endmodule

// File: rtl/pst_prot_check.sv
// Protection check: flags a page inside the upper region selected by the
// protect bits. Pure combinational. Assumes at least six page-address bits.
module pst_prot_check
    import pgm_status_pkg::*;
#(
    parameter int PAGE_AW = 12
) (
    input  logic [PAGE_AW-1:0] page,
    input  logic [BP_W-1:0]    bp,
    output logic               hit
);

    localparam int LO = PAGE_AW - PROT_TOP;

    logic [PROT_TOP-1:0] top;

    generate
        if (PAGE_AW < PROT_TOP) begin : g_bad_width
            $error("PAGE_AW must be at least six");
        end
    endgenerate

    assign top = page[LO +: PROT_TOP];

    // Region decode.
    always_comb begin
        hit = prot_hit(top, bp);
    end

endmodule

// File: rtl/pst_prog_timer.sv
// Program timer: a down-counter, loaded on start, that keeps the busy window
// open for PROG_CYCLES clocks. Flags the last cycle of the window.
// Assumes no start arrives while the window is open.
module pst_prog_timer #(
    parameter int PROG_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);

    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (start)       cnt <= CW'(PROG_CYCLES);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign last = (cnt == CW'(1));

endmodule

// File: rtl/pst_status_regs.sv
// Status registers: the write-enable latch and the protect bits.
// Order of effect: cycle completion clears the latch; when not busy, a
// protect write (which needs the latch) comes before write enable.
module pst_status_regs
    import pgm_status_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy_any,
    input  logic            done,
    input  logic            wren_req,
    input  logic            bp_wr_req,
    input  logic [BP_W-1:0] bp_wr_val,
    output logic            wel,
    output logic [BP_W-1:0] bp
);

    logic bp_take;

    assign bp_take = bp_wr_req & wel & ~busy_any;

    // Write-enable latch.
    always_ff @(posedge clk) begin
        if (!rst_n)         wel <= 1'b0;
        else if (done)      wel <= 1'b0;
        else if (!busy_any) begin
            if (bp_take)       wel <= 1'b0;
            else if (wren_req) wel <= 1'b1;
        end
    end

    // Protect bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       bp <= '0;
        else if (bp_take) bp <= bp_wr_val;
    end

endmodule

// File: rtl/pgm_status_tracker.sv
// Program-cycle status tracker: takes decoded page-program, write-enable and
// protect-write requests, starts a timed busy window when the program frame
// closes, and presents the status byte. Assumes all inputs are synchronous to clk.
module pgm_status_tracker
    import pgm_status_pkg::*;
#(
    parameter int PAGE_AW     = 12,
    parameter int PROG_CYCLES = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               pp_req,
    input  logic [PAGE_AW-1:0] pp_page,
    input  logic               wren_req,
    input  logic               bp_wr_req,
    input  logic [2:0]         bp_wr_val,
    input  logic               erase_busy,
    output logic [7:0]         status
);

    logic               cs_rise;
    logic               pend;
    logic [PAGE_AW-1:0] pend_page;
    logic               prot;
    logic               prog_busy;
    logic               prog_last;
    logic               busy_any;
    logic               start;
    logic               wel;
    logic [BP_W-1:0]    bp;
    stat_t              stat;

    pst_frame_capture #(.PAGE_AW(PAGE_AW)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .pp_req    (pp_req),
        .pp_page   (pp_page),
        .cs_rise   (cs_rise),
        .pend      (pend),
        .pend_page (pend_page)
    );

    pst_prot_check #(.PAGE_AW(PAGE_AW)) u_prot (
        .page (pend_page),
        .bp   (bp),
        .hit  (prot)
    );

    assign busy_any = prog_busy | erase_busy;
    assign start    = cs_rise & pend & wel & ~busy_any & ~prot;

    pst_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (prog_busy),
        .last  (prog_last)
    );

    pst_status_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_any  (busy_any),
        .done      (prog_last),
        .wren_req  (wren_req),
        .bp_wr_req (bp_wr_req),
        .bp_wr_val (bp_wr_val),
        .wel       (wel),
        .bp        (bp)
    );

    // Status byte assembly.
    always_comb begin
        stat.rsvd = '0;
        stat.bp   = bp;
        stat.wel  = wel;
        stat.wip  = busy_any;
        status    = stat;
    end

endmodule

// File: rtl/pgm_status_tracker_chk.sv
// Assertion checker for the tracker, bound to the top module below.
module pgm_status_tracker_chk #(
    parameter int PROG_CYCLES = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       erase_busy,
    input logic [7:0] status
);

    int run_len;

    // Length of the current busy run that the erase hook did not cause.
    always_ff @(posedge clk) begin
        if (!rst_n)                          run_len <= 0;
        else if (status[0] && !erase_busy)   run_len <= run_len + 1;
        else                                 run_len <= 0;
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) $rose(rst_n) |-> status == 8'h00); // R1

    AST_START_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) && !erase_busy && !$past(erase_busy) |-> $past(cs_n) && !$past(cs_n, 2)); // R3

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] && !erase_busy |-> run_len < PROG_CYCLES); // R4

    AST_WEL_DROP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) && !$past(erase_busy) |-> !status[1]); // R5

    AST_NO_START_WO_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        !status[1] && !status[0] |=> !status[0] || erase_busy); // R6

    AST_BP_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |=> $stable(status[4:2])); // R9

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[7:5] == 3'b000); // R11

endmodule

bind pgm_status_tracker pgm_status_tracker_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .erase_busy (erase_busy),
    .status     (status)
);

// File: tb/test_pgm_status_tracker.sv
`timescale 1ns/1ps
module test_pgm_status_tracker;

    localparam int AW   = 12;
    localparam int PROG = 24;
    localparam int MAXC = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          pp_req = 1'b0;
    logic [AW-1:0] pp_page = '0;
    logic          wren_req = 1'b0;
    logic          bp_wr_req = 1'b0;
    logic [2:0]    bp_wr_val = '0;
    logic          erase_busy = 1'b0;
    logic [7:0]    status;

    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    // Reference model state.
    bit          m_csq, m_pend, m_wel;
    logic [AW-1:0] m_page;
    logic [2:0]  m_bp;
    int          m_cnt;

    always #4 clk = ~clk;

    pgm_status_tracker #(.PAGE_AW(AW), .PROG_CYCLES(PROG)) i_pgm_status_tracker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pp_req(pp_req), .pp_page(pp_page),
        .wren_req(wren_req), .bp_wr_req(bp_wr_req), .bp_wr_val(bp_wr_val),
        .erase_busy(erase_busy), .status(status)
    );

    // Protection rule (R7), in 64ths of the array counted from the top.
    function automatic bit prot_ref(logic [AW-1:0] pg, logic [2:0] bp);
        int top = int'(pg >> (AW - 6));
        if (bp == 0) return 0;
        return top >= 64 - (1 << (int'(bp) - 1));
    endfunction

    function automatic logic [7:0] exp_status();
        return {3'b000, m_bp, m_wel, (m_cnt != 0) || erase_busy};
    endfunction

    // Cycle model, stepped on each rising edge with the inputs driven before it.
    always @(posedge clk) begin : model
        bit wip_v, rise_v, start_v, done_v, take_v;
        if (!rst_n) begin
            m_csq = 1; m_pend = 0; m_wel = 0; m_page = '0; m_bp = '0; m_cnt = 0;
        end else begin
            wip_v   = (m_cnt != 0) || erase_busy;
            rise_v  = cs_n && !m_csq;
            start_v = rise_v && m_pend && m_wel && !wip_v && !prot_ref(m_page, m_bp);
            done_v  = (m_cnt == 1);
            take_v  = bp_wr_req && m_wel && !wip_v;
            if (done_v) m_wel = 0;
            else if (!wip_v) begin
                if (take_v) m_wel = 0;
                else if (wren_req) m_wel = 1;
            end
            if (take_v) m_bp = bp_wr_val;
            if (start_v) m_cnt = PROG;
            else if (m_cnt != 0) m_cnt = m_cnt - 1;
            if (rise_v) m_pend = 0;
            else if (!cs_n && pp_req) begin m_pend = 1; m_page = pp_page; end
            m_csq = cs_n;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: rising edge, then compare with the model at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) chk("model R2 R3 R4 R5 R7 R8 R9 R10 R11", status, exp_status());
    endtask

    task automatic pulse_wren();
        wren_req = 1; step(); wren_req = 0;
    endtask

    task automatic pulse_bp(logic [2:0] v);
        bp_wr_req = 1; bp_wr_val = v; step(); bp_wr_req = 0;
    endtask

    // Page-program frame; returns just after the edge that sees cs_n high.
    task automatic frame(logic [AW-1:0] pg);
        cs_n = 0; step();
        pp_req = 1; pp_page = pg; step();
        pp_req = 0; cs_n = 1; step();
    endtask

    initial begin : watchdog
        repeat (MAXC) @(posedge clk);
        if (!done_run) begin
            errors++; checks++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        chk("R1 reset status", status, 8'h00);

        pulse_wren();
        chk("R2 latch set", status[1], 1);

        cs_n = 0; step();
        pp_req = 1; pp_page = 12'h000; step();
        pp_req = 0; step(); step();
        chk("R3 no start while cs low", status[0], 0);
        cs_n = 1; step();
        chk("R3 start on cs rise", status[0], 1);
        repeat (PROG - 1) step();
        chk("R4 busy on last cycle", status[0], 1);
        step();
        chk("R4 busy ends", status[0], 0);
        chk("R5 latch cleared at end", status[1], 0);

        frame(12'h000);
        chk("R6 no start without latch", status[0], 0);
        step();
        chk("R6 still idle", status[0], 0);

        pulse_bp(3'd5);
        chk("R9 protect write ignored without latch", status[4:2], 0);
        pulse_wren();
        pulse_bp(3'd1);
        chk("R9 protect loaded", status[4:2], 1);
        chk("R9 latch cleared by protect write", status[1], 0);

        pulse_wren();
        frame(12'hFC5);
        chk("R7 protected page dropped", status[0], 0);
        chk("R7 latch kept after refusal", status[1], 1);
        frame(12'hF80);
        chk("R7 page below region runs", status[0], 1);
        frame(12'h000);
        repeat (PROG - 4) step();
        chk("R8 window not extended, still busy", status[0], 1);
        step();
        chk("R8 window ends on time", status[0], 0);

        pulse_wren();
        pulse_bp(3'd7);
        pulse_wren();
        frame(12'h000);
        chk("R7 whole array protected", status[0], 0);
        chk("R7 latch kept", status[1], 1);
        pulse_bp(3'd0);
        chk("R9 protect cleared", status[4:2], 0);

        erase_busy = 1; step();
        chk("R10 erase hook shows busy", status[0], 1);
        pulse_wren();
        chk("R2 write enable ignored while busy", status[1], 0);
        erase_busy = 0; pulse_wren(); erase_busy = 1;
        frame(12'h000);
        erase_busy = 0; step();
        chk("R10 program dropped during erase", status[0], 0);
        chk("R11 upper bits zero", status[7:5], 0);

        for (int i = 0; i < 6000; i++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 20) cs_n = ~cs_n;
            pp_req = !cs_n && ($urandom_range(0, 2) == 0);
            case ($urandom_range(0, 4))
                0: pp_page = {6'd63, 6'($urandom)};
                1: pp_page = {6'd62, 6'($urandom)};
                2: pp_page = {6'd48, 6'($urandom)};
                3: pp_page = {6'd0, 6'($urandom)};
                default: pp_page = AW'($urandom);
            endcase
            wren_req  = ($urandom_range(0, 5) == 0);
            bp_wr_req = ($urandom_range(0, 11) == 0);
            bp_wr_val = 3'($urandom);
            if ($urandom_range(0, 59) == 0) erase_busy = ~erase_busy;
            step();
        end

        done_run = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule